// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-line configuration of an interrupt distributor: an enable bit, a trigger mode, a priority byte and, for shared lines, a CPU routing mask. It watches the interrupt inputs and turns them into pending state. Each line is either level sensed or latched on a rising edge. For every CPU it produces one vector of lines that are pending, enabled and routed to that CPU. Those vectors feed the per-CPU interfaces, which choose a winner and run the acknowledge handshake outside this block.

Software reaches the block through a flat 32-bit word bus. Writes are registered, reads are combinational, and every access carries the index of the requesting CPU. Lines 0 to 31 are private: each CPU has its own enable and priority state for them, its own trigger state for lines 16 to 31, and its own input wires. Lines 32 and above are shared between all CPUs and are steered by a routing mask. Addresses on the bus are word addresses.

Top module: `idist_regbank`

## Requirements
- R1: After reset the control bit, every enable, every priority byte, every stored trigger bit and every shared routing mask is zero, and no output bit is set.
- R2: Word 0x040+k sets and word 0x060+k clears the enable of line 32k+b for each 1 in data bit b. A 0 bit leaves the enable unchanged. Reading either word returns the current enables of lines 32k to 32k+31.
- R3: Word 0x300+k holds the trigger bits of lines 16k to 16k+15. Bit 2j+1 is 1 for rising-edge sensing of line 16k+j and 0 for level sensing. Bit 2j always reads 0.
- R4: Lines 0 to 15 are always edge sensed. Word 0x300 reads 0xAAAAAAAA and ignores writes.
- R5: Word 0x100+k holds the priority bytes of lines 4k to 4k+3, with line 4k+j in bits 8j+7..8j. The bytes read back as written.
- R6: Word 0x200+k holds 8-bit routing fields in the same byte layout as R5. Bit c of a shared line's field sends that line to CPU c. Field bits at or above NUM_CPU read 0.
- R7: For lines 0 to 31, enable, priority and trigger accesses reach only the copy that belongs to the CPU index given with the access. The routing field of such a line reads as that CPU's own bit. Private line i of CPU c is driven by priv_irq[32c+i] and is forwarded only to CPU c.
- R8: Bit 0 of word 0x000 is the global forward enable. While it is 0, every output bit is 0.
- R9: Word 0x001 is read only, and its low 5 bits hold NUM_IRQ/32-1. Lines at or above 1020 have no state and read as 0.
- R10: Unimplemented addresses read 0 and ignore writes. An access whose CPU index is at or above NUM_CPU reads 0 and changes nothing.
- R11: A level line is pending while its input is high. An edge line becomes pending on a 0-to-1 input transition and stays pending until a 1 is written to its bit in word 0x080+k. Reading word 0x080+k returns the pending bits of lines 32k to 32k+31.
- R12: Output bit cpu_irq_vec[c*NUM_IRQ+i] is 1 exactly when the control bit is set and line i, as seen by CPU c, is enabled, pending and routed to c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current access |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 3 | Index of the CPU making the access |
| bus_rdata | output | 32 | Combinational read data |
| priv_irq | input | NUM_CPU*32 | Private line inputs, 32 per CPU |
| spi_irq | input | NUM_IRQ-32 | Shared line inputs for lines 32 and up |
| cpu_irq_vec | output | NUM_CPU*NUM_IRQ | Forwarded lines, NUM_IRQ per CPU |

## Verification
The hardest situation to reach is the one where the private state of one CPU must stay untouched while another CPU index writes to the same word address. The only way to see this from the ports is to read the same word back under each CPU index. Each banking test therefore writes with one index and reads back under two. It also drives one CPU's private input and looks at the output bit of that line for both CPUs. The edge-latch test raises a shared input for a single cycle and drops it again before the output is sampled. Pending must then come from the latch and not from the input level. It is cleared only by the write-one-to-clear word.

// File: rtl/idist_pkg.sv
package idist_pkg;
   localparam int BUS_AW    = 10;
   localparam int MAX_LINES = 1020;

   localparam logic [1:0] RG_LOW = 2'd0;
   localparam logic [1:0] RG_PRI = 2'd1;
   localparam logic [1:0] RG_TGT = 2'd2;
   localparam logic [1:0] RG_CFG = 2'd3;

   localparam logic [2:0] SUB_MISC  = 3'd0;
   localparam logic [2:0] SUB_ENSET = 3'd2;
   localparam logic [2:0] SUB_ENCLR = 3'd3;
   localparam logic [2:0] SUB_PEND  = 3'd4;

   localparam logic [4:0] OFS_CTRL = 5'd0;
   localparam logic [4:0] OFS_TYPE = 5'd1;
endpackage

// File: rtl/idist_line_sense.sv
module idist_line_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic edge_mode,
   input  logic clr,
   output logic pend
);
   logic in_q;
   logic latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q    <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         in_q <= line_in;
         if (!edge_mode)
            latch_q <= 1'b0;
         else if (line_in && !in_q)
            latch_q <= 1'b1;
         else if (clr)
            latch_q <= 1'b0;
      end
   end

   assign pend = edge_mode ? latch_q : line_in;
endmodule

// File: rtl/idist_route.sv
module idist_route #(
   parameter int NUM_IRQ = 64
) (
   input  logic               glb_en,
   input  logic [NUM_IRQ-1:0] en_vec,
   input  logic [NUM_IRQ-1:0] pend_vec,
   input  logic [NUM_IRQ-1:0] route_vec,
   output logic [NUM_IRQ-1:0] fwd_vec
);
   assign fwd_vec = {NUM_IRQ{glb_en}} & en_vec & pend_vec & route_vec;
endmodule

// File: rtl/idist_regbank.sv
module idist_regbank
   import idist_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int NUM_CPU = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_we,
   input  logic [BUS_AW-1:0]          bus_addr,
   input  logic [31:0]                bus_wdata,
   input  logic [2:0]                 bus_cpu,
   output logic [31:0]                bus_rdata,
   input  logic [NUM_CPU*32-1:0]      priv_irq,
   input  logic [NUM_IRQ-33:0]        spi_irq,
   output logic [NUM_CPU*NUM_IRQ-1:0] cpu_irq_vec
);
   localparam int NLINES = (NUM_IRQ > MAX_LINES) ? MAX_LINES : NUM_IRQ;
   localparam int CW     = $clog2(NUM_CPU);
   localparam int NW32   = NUM_IRQ / 32;
   localparam int NW16   = NUM_IRQ / 16;
   localparam int NW4    = NUM_IRQ / 4;

   if (NUM_IRQ % 32 != 0 || NUM_IRQ < 64 || NUM_IRQ > 1024) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 32 in 64..1024");
   end
   if (NUM_CPU != 2 && NUM_CPU != 4 && NUM_CPU != 8) begin : g_bad_cpu
      $error("NUM_CPU must be 2, 4 or 8");
   end

   // access decode
   logic          cpu_ok, wr_ok;
   logic [CW-1:0] cpu_sel;
   logic [1:0]    rgn;
   logic [2:0]    sub;
   logic          hit_set, hit_clr, hit_pend, hit_pri, hit_tgt, hit_cfg;

   assign cpu_ok   = ({1'b0, bus_cpu} < 4'(NUM_CPU));
   assign cpu_sel  = bus_cpu[CW-1:0];
   assign wr_ok    = bus_we & cpu_ok;
   assign rgn      = bus_addr[9:8];
   assign sub      = bus_addr[7:5];
   assign hit_set  = (rgn == RG_LOW) && (sub == SUB_ENSET);
   assign hit_clr  = (rgn == RG_LOW) && (sub == SUB_ENCLR);
   assign hit_pend = (rgn == RG_LOW) && (sub == SUB_PEND);
   assign hit_pri  = (rgn == RG_PRI);
   assign hit_tgt  = (rgn == RG_TGT);
   assign hit_cfg  = (rgn == RG_CFG) && (bus_addr[7:6] == 2'b00);

   logic glb_en;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         glb_en <= 1'b0;
      else if (wr_ok && rgn == RG_LOW && sub == SUB_MISC && bus_addr[4:0] == OFS_CTRL)
         glb_en <= bus_wdata[0];
   end

   // per-CPU views of every line
   logic [NUM_IRQ-1:0] en_v    [NUM_CPU];
   logic [NUM_IRQ-1:0] pend_v  [NUM_CPU];
   logic [NUM_IRQ-1:0] edge_v  [NUM_CPU];
   logic [NUM_IRQ-1:0] route_v [NUM_CPU];
   logic [7:0]         pri_v   [NUM_CPU][NUM_IRQ];
   logic [7:0]         tgt_v   [NUM_CPU][NUM_IRQ];

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
      localparam int W32 = g / 32;
      localparam int B32 = g % 32;
      localparam int W4  = g / 4;
      localparam int B4  = g % 4;
      localparam int W16 = g / 16;
      localparam int B16 = g % 16;

      if (g >= NLINES) begin : g_none
         for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
            assign en_v[c][g]    = 1'b0;
            assign pend_v[c][g]  = 1'b0;
            assign edge_v[c][g]  = 1'b0;
            assign route_v[c][g] = 1'b0;
            assign pri_v[c][g]   = '0;
            assign tgt_v[c][g]   = '0;
         end
      end else begin : g_impl
         logic s_set, s_clr, s_pclr, s_pri;
         assign s_set  = wr_ok & hit_set  & (bus_addr[4:0] == 5'(W32)) & bus_wdata[B32];
         assign s_clr  = wr_ok & hit_clr  & (bus_addr[4:0] == 5'(W32)) & bus_wdata[B32];
         assign s_pclr = wr_ok & hit_pend & (bus_addr[4:0] == 5'(W32)) & bus_wdata[B32];
         assign s_pri  = wr_ok & hit_pri  & (bus_addr[7:0] == 8'(W4));

         if (g < 32) begin : g_bank
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
               logic       own, en_q, edge_b, pnd;
               logic [7:0] pri_q;
               assign own = (cpu_sel == CW'(c));

               if (g < 16) begin : g_fixed
                  assign edge_b = 1'b1;
               end else begin : g_cfg
                  logic s_cfg, edge_q;
                  assign s_cfg = wr_ok & hit_cfg & (bus_addr[5:0] == 6'(W16)) & own;
                  always_ff @(posedge clk or negedge rst_n) begin
                     if (!rst_n)     edge_q <= 1'b0;
                     else if (s_cfg) edge_q <= bus_wdata[2*B16+1];
                  end
                  assign edge_b = edge_q;
               end

               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) begin
                     en_q  <= 1'b0;
                     pri_q <= '0;
                  end else begin
                     if (s_set & own)      en_q <= 1'b1;
                     else if (s_clr & own) en_q <= 1'b0;
                     if (s_pri & own)      pri_q <= bus_wdata[8*B4 +: 8];
                  end
               end

               idist_line_sense i_sense (
                  .clk      (clk),
                  .rst_n    (rst_n),
                  .line_in  (priv_irq[c*32+g]),
                  .edge_mode(edge_b),
                  .clr      (s_pclr & own),
                  .pend     (pnd)
               );

               assign en_v[c][g]    = en_q;
               assign pend_v[c][g]  = pnd;
               assign edge_v[c][g]  = edge_b;
               assign route_v[c][g] = 1'b1;
               assign pri_v[c][g]   = pri_q;
               assign tgt_v[c][g]   = 8'(1) << c;
            end
         end else begin : g_shared
            logic               s_tgt, s_cfg, en_q, edge_q, pnd;
            logic [7:0]         pri_q;
            logic [NUM_CPU-1:0] tgt_q;
            assign s_tgt = wr_ok & hit_tgt & (bus_addr[7:0] == 8'(W4));
            assign s_cfg = wr_ok & hit_cfg & (bus_addr[5:0] == 6'(W16));

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  en_q   <= 1'b0;
                  edge_q <= 1'b0;
                  pri_q  <= '0;
                  tgt_q  <= '0;
               end else begin
                  if (s_set)      en_q <= 1'b1;
                  else if (s_clr) en_q <= 1'b0;
                  if (s_cfg)      edge_q <= bus_wdata[2*B16+1];
                  if (s_pri)      pri_q  <= bus_wdata[8*B4 +: 8];
                  if (s_tgt)      tgt_q  <= bus_wdata[8*B4 +: NUM_CPU];
               end
            end

            idist_line_sense i_sense (
               .clk      (clk),
               .rst_n    (rst_n),
               .line_in  (spi_irq[g-32]),
               .edge_mode(edge_q),
               .clr      (s_pclr),
               .pend     (pnd)
            );

            for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
               assign en_v[c][g]    = en_q;
               assign pend_v[c][g]  = pnd;
               assign edge_v[c][g]  = edge_q;
               assign route_v[c][g] = tgt_q[c];
               assign pri_v[c][g]   = pri_q;
               assign tgt_v[c][g]   = 8'(tgt_q);
            end
         end
      end
   end

   // forwarding per CPU
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_fwd
      idist_route #(.NUM_IRQ(NUM_IRQ)) i_route (
         .glb_en   (glb_en),
         .en_vec   (en_v[c]),
         .pend_vec (pend_v[c]),
         .route_vec(route_v[c]),
         .fwd_vec  (cpu_irq_vec[c*NUM_IRQ +: NUM_IRQ])
      );
   end

   // read words, seen from the accessing CPU
   logic [31:0] en_word  [32];
   logic [31:0] pend_word[32];
   logic [31:0] cfg_word [64];
   logic [31:0] pri_word [256];
   logic [31:0] tgt_word [256];

   for (genvar w = 0; w < 32; w++) begin : g_w32
      if (w < NW32) begin : g_on
         assign en_word[w]   = en_v[cpu_sel][w*32 +: 32];
         assign pend_word[w] = pend_v[cpu_sel][w*32 +: 32];
      end else begin : g_off
         assign en_word[w]   = '0;
         assign pend_word[w] = '0;
      end
   end

   for (genvar w = 0; w < 64; w++) begin : g_w16
      if (w < NW16) begin : g_on
         for (genvar k = 0; k < 16; k++) begin : g_k
            assign cfg_word[w][2*k+1] = edge_v[cpu_sel][16*w+k];
            assign cfg_word[w][2*k]   = 1'b0;
         end
      end else begin : g_off
         assign cfg_word[w] = '0;
      end
   end

   for (genvar w = 0; w < 256; w++) begin : g_w4
      if (w < NW4) begin : g_on
         assign pri_word[w] = {pri_v[cpu_sel][4*w+3], pri_v[cpu_sel][4*w+2],
                               pri_v[cpu_sel][4*w+1], pri_v[cpu_sel][4*w]};
         assign tgt_word[w] = {tgt_v[cpu_sel][4*w+3], tgt_v[cpu_sel][4*w+2],
                               tgt_v[cpu_sel][4*w+1], tgt_v[cpu_sel][4*w]};
      end else begin : g_off
         assign pri_word[w] = '0;
         assign tgt_word[w] = '0;
      end
   end

   logic [31:0] rd;
   always_comb begin
      rd = '0;
      case (rgn)
         RG_LOW: begin
            case (sub)
               SUB_MISC: begin
                  if (bus_addr[4:0] == OFS_CTRL)      rd = {31'b0, glb_en};
                  else if (bus_addr[4:0] == OFS_TYPE) rd = 32'(NW32 - 1);
               end
               SUB_ENSET, SUB_ENCLR: rd = en_word[bus_addr[4:0]];
               SUB_PEND:             rd = pend_word[bus_addr[4:0]];
               default:              rd = '0;
            endcase
         end
         RG_PRI: rd = pri_word[bus_addr[7:0]];
         RG_TGT: rd = tgt_word[bus_addr[7:0]];
         default: if (bus_addr[7:6] == 2'b00) rd = cfg_word[bus_addr[5:0]];
      endcase
   end

   assign bus_rdata = cpu_ok ? rd : '0;
endmodule

// File: rtl/idist_chk.sv
module idist_chk #(
   parameter int NUM_IRQ = 64,
   parameter int NUM_CPU = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_we,
   input logic [9:0]                 bus_addr,
   input logic [31:0]                bus_wdata,
   input logic [2:0]                 bus_cpu,
   input logic [31:0]                bus_rdata,
   input logic                       glb_en,
   input logic [NUM_CPU*NUM_IRQ-1:0] cpu_irq_vec
);
   logic cpu_ok;
   assign cpu_ok = ({1'b0, bus_cpu} < 4'(NUM_CPU));

   a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> (cpu_irq_vec == '0));

   a_r8_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && cpu_ok && bus_addr == 10'h000) |=> (glb_en == $past(bus_wdata[0])));

   a_r4_cfg_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ok && bus_addr == 10'h300) |-> (bus_rdata == 32'hAAAA_AAAA));

   a_r9_type_word: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ok && bus_addr == 10'h001) |-> (bus_rdata == 32'(NUM_IRQ/32 - 1)));

   a_r10_bad_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ok |-> (bus_rdata == '0));

   a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_we && cpu_ok && bus_addr == 10'h040) && !bus_we
       && bus_addr == 10'h040 && bus_cpu == $past(bus_cpu))
      |-> ((bus_rdata & $past(bus_wdata)) == $past(bus_wdata)));
endmodule

bind idist_regbank idist_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_cpu    (bus_cpu),
   .bus_rdata  (bus_rdata),
   .glb_en     (glb_en),
   .cpu_irq_vec(cpu_irq_vec)
);

// File: tb/test_idist_regbank.sv
module test_idist_regbank;
   localparam int NI = 64;
   localparam int NC = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [9:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [2:0]        bus_cpu = '0;
   logic [31:0]       bus_rdata;
   logic [NC*32-1:0]  priv_irq = '0;
   logic [NI-33:0]    spi_irq = '0;
   logic [NC*NI-1:0]  cpu_irq_vec;

   int n_cmp = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   idist_regbank #(.NUM_IRQ(NI), .NUM_CPU(NC)) i_idist_regbank (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
      .priv_irq(priv_irq), .spi_irq(spi_irq), .cpu_irq_vec(cpu_irq_vec)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] cpu, input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_cpu = cpu; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] cpu, input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_cpu = cpu; bus_addr = a; bus_we = 1'b0;
      #2 d = bus_rdata;
   endtask

   function automatic logic [31:0] outbit(input int c, input int line);
      return {31'b0, cpu_irq_vec[c*NI+line]};
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(0, 10'h000, d); chk("R1 ctrl", d, 0);
      rd(0, 10'h041, d); chk("R1 enable word1", d, 0);
      rd(2, 10'h108, d); chk("R1 priority", d, 0);
      rd(0, 10'h208, d); chk("R1 shared target", d, 0);
      rd(1, 10'h200, d); chk("R7 banked target reads own bit", d, 32'h0202_0202);
      chk("R1 outputs", {31'b0, |cpu_irq_vec}, 0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(0, 10'h041, 32'h0000_00F0);
      rd(0, 10'h041, d); chk("R2 set readback", d, 32'hF0);
      rd(0, 10'h061, d); chk("R2 clear word reads enables", d, 32'hF0);
      wr(0, 10'h061, 32'h0000_0030);
      rd(0, 10'h041, d); chk("R2 clear", d, 32'hC0);
      wr(0, 10'h041, 32'h0);
      rd(0, 10'h041, d); chk("R2 zero write no effect", d, 32'hC0);
   endtask

   task automatic t_cfg();
      logic [31:0] d;
      wr(0, 10'h300, 32'h0);
      rd(0, 10'h300, d); chk("R4 fixed config", d, 32'hAAAA_AAAA);
      wr(0, 10'h302, 32'hFFFF_FFFF);
      rd(0, 10'h302, d); chk("R3 config upper bits only", d, 32'hAAAA_AAAA);
      wr(0, 10'h302, 32'h0);
      rd(0, 10'h302, d); chk("R3 config back to level", d, 0);
   endtask

   task automatic t_priority();
      logic [31:0] d;
      wr(0, 10'h108, 32'h1122_3344);
      rd(3, 10'h108, d); chk("R5 shared priority", d, 32'h1122_3344);
      wr(2, 10'h100, 32'hA0A0_A0A0);
      rd(2, 10'h100, d); chk("R7 banked priority own", d, 32'hA0A0_A0A0);
      rd(0, 10'h100, d); chk("R7 banked priority other", d, 0);
   endtask

   task automatic t_target();
      logic [31:0] d;
      wr(0, 10'h209, 32'hFFFF_FFFF);
      rd(0, 10'h209, d); chk("R6 target upper bits drop", d, 32'h0F0F_0F0F);
   endtask

   task automatic t_level_route();
      logic [31:0] d;
      wr(0, 10'h000, 32'h1);
      wr(0, 10'h041, 32'h0000_0002);
      wr(0, 10'h208, 32'h0000_0400);
      @(negedge clk); spi_irq[1] = 1'b1;
      #2;
      chk("R12 level to cpu2", outbit(2, 33), 1);
      chk("R6 not routed to cpu0", outbit(0, 33), 0);
      rd(0, 10'h081, d); chk("R11 level pending read", d[1] ? 32'h1 : 32'h0, 1);
      wr(0, 10'h000, 32'h0);
      #2 chk("R8 global off", {31'b0, |cpu_irq_vec}, 0);
      wr(0, 10'h000, 32'h1);
      @(negedge clk); spi_irq[1] = 1'b0;
      #2 chk("R11 level follows input", outbit(2, 33), 0);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      wr(0, 10'h302, 32'h0000_0020);
      wr(0, 10'h041, 32'h0000_0004);
      wr(0, 10'h208, 32'h0001_0400);
      @(negedge clk); spi_irq[2] = 1'b1;
      @(negedge clk); spi_irq[2] = 1'b0;
      @(negedge clk);
      #2 chk("R11 edge latched", outbit(0, 34), 1);
      rd(0, 10'h081, d); chk("R11 edge pending read", d & 32'h4, 32'h4);
      wr(0, 10'h081, 32'h0000_0004);
      #2 chk("R11 edge cleared", outbit(0, 34), 0);
   endtask

   task automatic t_bank();
      logic [31:0] d;
      wr(1, 10'h040, 32'h0010_0000);
      rd(1, 10'h040, d); chk("R7 banked enable own", d, 32'h0010_0000);
      rd(0, 10'h040, d); chk("R7 banked enable other", d, 0);
      @(negedge clk); priv_irq[1*32+20] = 1'b1;
      #2;
      chk("R7 private line to own cpu", outbit(1, 20), 1);
      chk("R7 private line not elsewhere", outbit(0, 20), 0);
      @(negedge clk); priv_irq[1*32+20] = 1'b0;
      wr(1, 10'h301, 32'h0000_0200);
      rd(1, 10'h301, d); chk("R7 banked config own", d, 32'h0000_0200);
      rd(0, 10'h301, d); chk("R7 banked config other", d, 0);
   endtask

   task automatic t_misc();
      logic [31:0] d;
      rd(0, 10'h001, d); chk("R9 type word", d, 32'h1);
      wr(0, 10'h0A0, 32'hFFFF_FFFF);
      rd(0, 10'h0A0, d); chk("R10 unimplemented word", d, 0);
      rd(0, 10'h3FF, d); chk("R10 unimplemented config area", d, 0);
      rd(0, 10'h042, d); chk("R9 no lines beyond count", d, 0);
      rd(5, 10'h000, d); chk("R10 bad cpu read", d, 0);
      wr(5, 10'h061, 32'hFFFF_FFFF);
      rd(0, 10'h041, d); chk("R10 bad cpu write ignored", d, 32'h0000_00C6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_cfg();
      t_priority();
      t_target();
      t_level_route();
      t_edge();
      t_bank();
      t_misc();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end
endmodule